// File: doc/BRIEF.md
# Trace Data Monitor with Masked Pattern Triggers

This block watches a multi-bit input bus once per clock and turns the samples into trace data elements for a downstream aggregator. A small write-only configuration port sets the collection controls, the timestamp-request causes and two masked pattern comparators. One comparator marks elements that need a timestamp. The other raises a one-cycle trigger pulse.

Each emitted element appears on `elem_valid`/`elem_data` one clock after its sample. A per-element flag, `elem_ts`, asks the aggregator to insert a timestamp. There are two collection modes. Continuous mode emits every sample. Change-only mode emits a sample only when it differs from the last emitted element. A timestamp can be requested for three reasons, each enabled separately: a masked pattern hit, an external cross-trigger request, or a request on every element.

Configuration map (address on `cfg_addr`):

| Address | Content |
|---|---|
| 0 | bit 0 collection enable, bit 1 mode (0 continuous, 1 change-only) |
| 1 | bit 0 timestamp on pattern hit, bit 1 timestamp on cross-trigger, bit 2 timestamp on every element |
| 2 / 3 | timestamp pattern / timestamp mask |
| 4 / 5 | trigger pattern / trigger mask |

All configuration registers reset to zero.

Top module: `trace_monitor`

## Requirements
- R1: While control bit 0 is 0, `elem_valid`, `elem_ts` and `trig_pulse` stay low whatever the input bus does.
- R2: With control bit 0 = 1 and bit 1 = 0, every sample produces an element carrying that sample, one clock after the sample, including repeated values.
- R3: With control bit 1 = 1, a sample is emitted only when it differs from the data of the previous emitted element.
- R4: In change-only mode, the first sample after collection turns on is always emitted, even if it equals the last element emitted before the block was disabled.
- R5: When address-1 bit 0 is set, an element has `elem_ts` = 1 if `(data ^ ts_pattern) & ts_mask` is zero.
- R6: When address-1 bit 1 is set, a high `xtrig_ts_req` is held pending until the next emitted element. That element has `elem_ts` = 1, and the pending request is then cleared. This includes a request that arrives in the same cycle as the sample.
- R7: When address-1 bit 2 is set, every emitted element has `elem_ts` = 1.
- R8: A mask bit of 1 includes that bit position in the comparison. An all-zero mask matches every element.
- R9: `trig_pulse` is high for exactly the output cycle of an emitted element whose data matches the trigger pattern under the trigger mask, and it is low otherwise.
- R10: A configuration write takes effect from the cycle after the write. A sample taken during the write cycle uses the old settings.
- R11: During and immediately after reset, `elem_valid`, `elem_ts` and `trig_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| smp_data | input | DATA_W | Monitored input bus, sampled every clock |
| xtrig_ts_req | input | 1 | External cross-trigger timestamp request |
| elem_valid | output | 1 | An element is present this cycle |
| elem_data | output | DATA_W | Element data |
| elem_ts | output | 1 | Timestamp requested for this element |
| trig_pulse | output | 1 | Trigger-pattern hit on this element |

## Verification
The hardest case to reach is a cross-trigger request that has to survive several cycles with no emission. To set it up, the stimulus first pulses `xtrig_ts_req` while collection is off. It then pulses it again in change-only mode while the bus holds a constant value, so no element is produced. The stimulus then checks that the timestamp flag appears on the next element and on none after it. A second case re-enables collection with the same value that was emitted last. The element must still appear, which shows that the previous-value comparison is reloaded.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int CFG_ADDR_W = 3;

    localparam logic [CFG_ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [CFG_ADDR_W-1:0] A_TSEN   = 3'd1;
    localparam logic [CFG_ADDR_W-1:0] A_TS_PAT = 3'd2;
    localparam logic [CFG_ADDR_W-1:0] A_TS_MSK = 3'd3;
    localparam logic [CFG_ADDR_W-1:0] A_TG_PAT = 3'd4;
    localparam logic [CFG_ADDR_W-1:0] A_TG_MSK = 3'd5;

    typedef struct packed {
        logic en;
        logic on_change;
        logic ts_pat;
        logic ts_xt;
        logic ts_all;
    } ctl_t;
endpackage

// File: rtl/tm_match.sv
module tm_match #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] pattern,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    logic [DATA_W-1:0] diff;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign diff[b] = mask[b] & (data[b] ^ pattern[b]);
        end
    endgenerate

    assign hit = ~|diff;
endmodule

// File: rtl/tm_cfg.sv
module tm_cfg
    import tm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CFG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output ctl_t                  ctl,
    output logic [DATA_W-1:0]     ts_pat,
    output logic [DATA_W-1:0]     ts_msk,
    output logic [DATA_W-1:0]     tg_pat,
    output logic [DATA_W-1:0]     tg_msk
);
    typedef struct packed {
        ctl_t              c;
        logic [DATA_W-1:0] tp;
        logic [DATA_W-1:0] tm;
        logic [DATA_W-1:0] gp;
        logic [DATA_W-1:0] gm;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                A_CTRL: begin
                    r_d.c.en        = wdata[0];
                    r_d.c.on_change = wdata[1];
                end
                A_TSEN: begin
                    r_d.c.ts_pat = wdata[0];
                    r_d.c.ts_xt  = wdata[1];
                    r_d.c.ts_all = wdata[2];
                end
                A_TS_PAT: r_d.tp = wdata;
                A_TS_MSK: r_d.tm = wdata;
                A_TG_PAT: r_d.gp = wdata;
                A_TG_MSK: r_d.gm = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctl    = r_q.c;
    assign ts_pat = r_q.tp;
    assign ts_msk = r_q.tm;
    assign tg_pat = r_q.gp;
    assign tg_msk = r_q.gm;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we) |-> $stable(r_q)); // R10
endmodule

// File: rtl/trace_monitor.sv
module trace_monitor
    import tm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [DATA_W-1:0]     smp_data,
    input  logic                  xtrig_ts_req,
    output logic                  elem_valid,
    output logic [DATA_W-1:0]     elem_data,
    output logic                  elem_ts,
    output logic                  trig_pulse
);
    ctl_t              ctl;
    logic [DATA_W-1:0] ts_pat, ts_msk, tg_pat, tg_msk;
    logic              ts_hit, tg_hit;

    tm_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .ctl    (ctl),
        .ts_pat (ts_pat),
        .ts_msk (ts_msk),
        .tg_pat (tg_pat),
        .tg_msk (tg_msk)
    );

    tm_match #(.DATA_W(DATA_W)) u_ts_match (
        .data (smp_data), .pattern (ts_pat), .mask (ts_msk), .hit (ts_hit)
    );

    tm_match #(.DATA_W(DATA_W)) u_tg_match (
        .data (smp_data), .pattern (tg_pat), .mask (tg_msk), .hit (tg_hit)
    );

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              ts;
        logic              trig;
        logic              first;
        logic [DATA_W-1:0] prev;
        logic              pend;
    } st_t;

    st_t  st_d, st_q;
    logic emit;
    logic ts_req;

    always_comb begin
        st_d   = st_q;
        emit   = ctl.en && (!ctl.on_change || st_q.first || (smp_data != st_q.prev));
        ts_req = ctl.ts_all
               | (ctl.ts_pat & ts_hit)
               | (ctl.ts_xt & (st_q.pend | xtrig_ts_req));

        st_d.valid = emit;
        st_d.data  = emit ? smp_data : st_q.data;
        st_d.ts    = emit & ts_req;
        st_d.trig  = emit & tg_hit;
        st_d.prev  = emit ? smp_data : st_q.prev;
        st_d.pend  = emit ? 1'b0 : (st_q.pend | xtrig_ts_req);
        if (!ctl.en)   st_d.first = 1'b1;
        else if (emit) st_d.first = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign elem_valid = st_q.valid;
    assign elem_data  = st_q.data;
    assign elem_ts    = st_q.ts;
    assign trig_pulse = st_q.trig;

    AST_OFF_NO_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl.en) |-> !elem_valid); // R1
    AST_CONT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl.en && !ctl.on_change) |-> elem_valid); // R2
    AST_TRIG_ON_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> elem_valid); // R9
    AST_TS_ON_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        elem_ts |-> elem_valid); // R7
    AST_XT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> !st_q.pend); // R6
    AST_CHG_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl.en && ctl.on_change && !st_q.first) && elem_valid)
            |-> (elem_data != $past(st_q.prev))); // R3
endmodule

// File: tb/tb_trace_monitor.sv
module tb_trace_monitor;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic [W-1:0] smp_data = '0;
    logic         xtrig_ts_req = 1'b0;
    logic         elem_valid, elem_ts, trig_pulse;
    logic [W-1:0] elem_data;

    always #2.5 clk = ~clk;

    trace_monitor #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_data(smp_data), .xtrig_ts_req(xtrig_ts_req),
        .elem_valid(elem_valid), .elem_data(elem_data), .elem_ts(elem_ts),
        .trig_pulse(trig_pulse)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_tag = "R11";

    logic         q_v[$];
    logic [W-1:0] q_d[$];
    logic         q_ts[$];
    logic         q_tg[$];
    string        q_tag[$];

    // shadow model
    logic m_en = 0, m_chg = 0, m_tp = 0, m_tx = 0, m_ta = 0;
    logic [W-1:0] m_tsp = 0, m_tsm = 0, m_tgp = 0, m_tgm = 0;
    logic m_first = 1, m_pend = 0;
    logic [W-1:0] m_prev = 0;

    task automatic cyc(input logic we, input logic [2:0] a, input logic [W-1:0] wd,
                       input logic [W-1:0] d, input logic xt);
        logic e, ts, tg;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = wd; smp_data = d; xtrig_ts_req = xt;
        e  = m_en && (!m_chg || m_first || d != m_prev);
        ts = e && (m_ta || (m_tp && (((d ^ m_tsp) & m_tsm) == 0)) || (m_tx && (m_pend || xt)));
        tg = e && (((d ^ m_tgp) & m_tgm) == 0);
        q_v.push_back(e); q_d.push_back(d); q_ts.push_back(ts); q_tg.push_back(tg);
        q_tag.push_back(cur_tag);
        m_pend  = e ? 1'b0 : (m_pend | xt);
        if (!m_en) m_first = 1'b1; else if (e) m_first = 1'b0;
        if (e) m_prev = d;
        if (we) begin
            case (a)
                3'd0: begin m_en = wd[0]; m_chg = wd[1]; end
                3'd1: begin m_tp = wd[0]; m_tx = wd[1]; m_ta = wd[2]; end
                3'd2: m_tsp = wd;
                3'd3: m_tsm = wd;
                3'd4: m_tgp = wd;
                3'd5: m_tgm = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] wd, input logic [W-1:0] d);
        cyc(1'b1, a, wd, d, 1'b0);
    endtask

    task automatic smp(input logic [W-1:0] d, input logic xt = 1'b0);
        cyc(1'b0, 3'd0, '0, d, xt);
    endtask

    // monitor: compare one expected item per clock
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q_v.size() > 0) begin
                logic ev, ets, etg; logic [W-1:0] ed; string tg;
                ev = q_v.pop_front(); ed = q_d.pop_front(); ets = q_ts.pop_front();
                etg = q_tg.pop_front(); tg = q_tag.pop_front();
                n_cmp++;
                if (elem_valid !== ev || elem_ts !== ets || trig_pulse !== etg ||
                    (ev && elem_data !== ed)) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b d=%h ts=%0b tg=%0b exp v=%0b d=%h ts=%0b tg=%0b",
                             tg, elem_valid, elem_data, elem_ts, trig_pulse, ev, ed, ets, etg);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung exp finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_cmp++; // R11 during reset
        if (elem_valid !== 0 || elem_ts !== 0 || trig_pulse !== 0) begin
            n_bad++;
            $display("FAIL R11: got v=%0b ts=%0b tg=%0b exp 0 0 0", elem_valid, elem_ts, trig_pulse);
        end
        @(negedge clk); rst_n = 1'b1;
        cur_tag = "R11"; smp(32'h1);
        // R1: disabled, bus toggles, xtrig latched for later
        cur_tag = "R1";
        smp(32'h11); smp(32'h22); smp(32'h33, 1'b1); smp(32'h44);
        // R10: xt cause enabled; enable written while 0x55 sampled: no element for it
        cur_tag = "R10";
        wr(3'd1, 32'h2, 32'h50);
        wr(3'd0, 32'h1, 32'h55);
        // R6: first element carries the pending request, next does not
        cur_tag = "R6";
        smp(32'h66); smp(32'h66);
        // R2 + R8: continuous, repeats emitted, zero trigger mask hits all
        cur_tag = "R2"; smp(32'h66); smp(32'h77); smp(32'h77);
        cur_tag = "R8"; smp(32'hDEAD); smp(32'h0);
        // R9: trigger pattern on low byte
        cur_tag = "R9";
        wr(3'd4, 32'hA5, 32'h1);
        wr(3'd5, 32'hFF, 32'h12A5);
        smp(32'h12A5); smp(32'h12A4); smp(32'h99A5); smp(32'h00A5);
        // R5: timestamp pattern on top nibble, with R8 mask semantics
        cur_tag = "R5";
        wr(3'd2, 32'hF000_0000, 32'h0);
        wr(3'd3, 32'hF000_0000, 32'h0);
        wr(3'd1, 32'h1, 32'hF000_0000);
        smp(32'hF123_4567); smp(32'hE123_4567); smp(32'hFFFF_FFFF);
        // R7: every element
        cur_tag = "R7";
        wr(3'd1, 32'h4, 32'h5);
        smp(32'h6); smp(32'h6); smp(32'h0);
        // R3: change-only mode
        cur_tag = "R3";
        wr(3'd1, 32'h2, 32'h0);
        wr(3'd0, 32'h3, 32'h7);
        smp(32'h1); smp(32'h1); smp(32'h2); smp(32'h2); smp(32'h2); smp(32'h3); smp(32'h1);
        // R6: request while no element, held until the next change
        cur_tag = "R6";
        smp(32'h1, 1'b1); smp(32'h1); smp(32'h1); smp(32'h9); smp(32'hA); smp(32'hA);
        smp(32'hB, 1'b1); smp(32'hC);
        // R4: disable then re-enable with the same value as last element
        cur_tag = "R4";
        wr(3'd0, 32'h2, 32'hC);
        smp(32'hC); smp(32'hC);
        wr(3'd0, 32'h3, 32'hC);
        smp(32'hC); smp(32'hC); smp(32'hD);
        // R1: disable again, quiet output
        cur_tag = "R1";
        wr(3'd0, 32'h0, 32'h5);
        smp(32'h6, 1'b1); smp(32'h7); smp(32'h8);
        @(negedge clk); cfg_we = 0;
        repeat (3) @(posedge clk);
        #2;
        if (q_v.size() != 0) begin
            n_bad++;
            $display("FAIL R9: got %0d pending exp 0", q_v.size());
        end
        finish_run();
    end
endmodule